// File: doc/BRIEF.md
# Translation Unit Control Registers

This block is the software-facing control face of a paged I/O address translation unit. Through a 32-bit register port it holds the base address of the first-level directory, reports the unit's operating flags, and accepts one-word commands. These commands turn translation on or off, freeze or release the datapath, drop every cached translation, acknowledge a page fault, or return every register to its reset value. The table walk itself lives elsewhere. This block only drives the enable, stall and invalidate strobes that the walker obeys, and it receives the walker's fault and bus-error events.

The events land in a small interrupt bank with a raw status, an enable mask and a masked view. The interrupt line is the OR of the masked view. Software reads the fault address and direction, writes the acknowledge command, and clears the raw bits by writing ones. A separate register turns a written address into a one-cycle single-line invalidate strobe.

Top module: `xlat_ctl`

## Requirements
- R1: After reset the base register, paging, stall, fault-active, raw status, mask and irq are all zero. The status word then reads with bit 31 set, bit 3 equal to dp_idle, bit 4 equal to dp_replay_empty, and every other bit clear.
- R2: The directory base register at offset 0x00 keeps only bits 31:12 of a write, and its low 12 bits read as zero. Writing 0xCAFEBABE reads back 0xCAFEB000, and the same value appears on base_addr.
- R3: Writing command 0 to offset 0x08 sets xlat_en and status bit 0. Command 1 clears them, and it also clears stall.
- R4: Command 2 sets stall_on and status bit 2 only while paging is on, and otherwise it has no effect. Command 3 clears stall. Status bit 31 always reads as the inverse of bit 2.
- R5: Command 4 makes flush_all high for exactly the one cycle after the write.
- R6: A write to offset 0x10 makes inv_line high for the one cycle after the write, with inv_addr equal to the written word.
- R7: A pulse on evt_fault sets status bit 1 and raw bit 0. It copies evt_write into status bit 5 and evt_addr into offset 0x0C. Command 5 clears status bit 1.
- R8: A pulse on evt_bus_err sets raw bit 1. Raw status reads at 0x14, the mask at 0x1C, and the masked status at 0x20 equals raw AND mask. irq is high exactly when the masked status is non-zero.
- R9: Writing to offset 0x18 clears each raw bit written as 1. An event in the same cycle as the clear keeps its bit set.
- R10: Command 6 returns every register to its R1 value one cycle after the write. The base register then reads zero.
- R11: Reads of offsets that hold no register return zero. Command values of 7 or above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_fault | input | 1 | Page fault event from the walker |
| evt_write | input | 1 | Faulting access was a write |
| evt_addr | input | 32 | Faulting I/O virtual address |
| evt_bus_err | input | 1 | Bus read error event from the walker |
| dp_idle | input | 1 | Datapath idle flag |
| dp_replay_empty | input | 1 | Datapath replay buffer empty flag |
| xlat_en | output | 1 | Translation enabled |
| stall_on | output | 1 | Datapath stall request |
| flush_all | output | 1 | One-cycle strobe to drop all cached translations |
| inv_line | output | 1 | One-cycle strobe to drop one cached translation |
| inv_addr | output | 32 | Address carried with inv_line |
| base_addr | output | 32 | Directory base address |
| irq | output | 1 | Interrupt request |

## Verification
Every write and every event takes effect at the first rising edge that samples it. Registered state, both strobes and irq therefore change one cycle after the stimulus, and reads are combinational from that state. The bench drives inputs on the falling edge and releases them on the next falling edge, then checks outputs and read data at that point, between edges. Each strobe is checked at that point as high and again one falling edge later as low.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

  localparam logic [7:0] OFF_BASE   = 8'h00;
  localparam logic [7:0] OFF_STATUS = 8'h04;
  localparam logic [7:0] OFF_CMD    = 8'h08;
  localparam logic [7:0] OFF_FADDR  = 8'h0C;
  localparam logic [7:0] OFF_INV    = 8'h10;
  localparam logic [7:0] OFF_RAW    = 8'h14;
  localparam logic [7:0] OFF_CLR    = 8'h18;
  localparam logic [7:0] OFF_MASK   = 8'h1C;
  localparam logic [7:0] OFF_MSKD   = 8'h20;

  typedef enum logic [2:0] {
    OP_PAGE_ON   = 3'd0,
    OP_PAGE_OFF  = 3'd1,
    OP_STALL_ON  = 3'd2,
    OP_STALL_OFF = 3'd3,
    OP_FLUSH     = 3'd4,
    OP_FAULT_ACK = 3'd5,
    OP_SOFT_RST  = 3'd6,
    OP_NONE      = 3'd7
  } op_e;

  // Clears the bits below 'lo', keeping the page-aligned part.
  function automatic logic [31:0] keep_upper(input logic [31:0] d, input int unsigned lo);
    return d & ~((32'd1 << lo) - 32'd1);
  endfunction

  // Raw status update: a set beats a clear on the same bit.
  function automatic logic raw_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Status word layout: 0 paging, 1 fault, 2 stall, 3 idle, 4 replay empty, 5 write fault, 31 not stalled.
  function automatic logic [31:0] pack_status(input logic paging, input logic fault,
                                              input logic stall, input logic idle,
                                              input logic replay, input logic fwr);
    return {~stall, 25'd0, fwr, replay, idle, stall, fault, paging};
  endfunction

endpackage

// File: rtl/xlat_ctl_mode.sv
module xlat_ctl_mode
  import xlat_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_hit,
  input  op_e  op_code,
  output logic paging,
  output logic stall,
  output logic flush
);

  logic go_page_on, go_page_off, go_stall_on, go_stall_off, go_flush, go_rst;

  always_comb begin
    go_page_on   = op_hit && (op_code == OP_PAGE_ON);
    go_page_off  = op_hit && (op_code == OP_PAGE_OFF);
    go_stall_on  = op_hit && (op_code == OP_STALL_ON) && paging;
    go_stall_off = op_hit && (op_code == OP_STALL_OFF);
    go_flush     = op_hit && (op_code == OP_FLUSH);
    go_rst       = op_hit && (op_code == OP_SOFT_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paging <= 1'b0;
      stall  <= 1'b0;
      flush  <= 1'b0;
    end else begin
      flush <= go_flush;
      if (go_rst) begin
        paging <= 1'b0;
        stall  <= 1'b0;
      end else begin
        if (go_page_on)  paging <= 1'b1;
        if (go_page_off) paging <= 1'b0;
        if (go_page_off || go_stall_off) stall <= 1'b0;
        else if (go_stall_on)            stall <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/xlat_ctl_fault.sv
module xlat_ctl_fault #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          ack,
  input  logic          evt_fault,
  input  logic          evt_write,
  input  logic [DW-1:0] evt_addr,
  output logic          active,
  output logic          was_write,
  output logic [DW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      was_write <= 1'b0;
      addr      <= '0;
    end else if (sw_rst) begin
      active    <= 1'b0;
      was_write <= 1'b0;
      addr      <= '0;
    end else if (evt_fault) begin
      active    <= 1'b1;
      was_write <= evt_write;
      addr      <= evt_addr;
    end else if (ack) begin
      active    <= 1'b0;
    end
  end

endmodule

// File: rtl/xlat_ctl_irq.sv
module xlat_ctl_irq
  import xlat_ctl_pkg::*;
#(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] masked,
  output logic            irq
);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw[g] <= 1'b0;
      else if (sw_rst) raw[g] <= 1'b0;
      else             raw[g] <= raw_next(raw[g], set_vec[g], clr_vec[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (sw_rst)  mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  assign masked = raw & mask;
  assign irq    = |masked;

endmodule

// File: rtl/xlat_ctl.sv
module xlat_ctl
  import xlat_ctl_pkg::*;
#(
  parameter int unsigned REG_AW     = 8,
  parameter int unsigned DW         = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned NSRC       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              evt_fault,
  input  logic              evt_write,
  input  logic [DW-1:0]     evt_addr,
  input  logic              evt_bus_err,
  input  logic              dp_idle,
  input  logic              dp_replay_empty,
  output logic              xlat_en,
  output logic              stall_on,
  output logic              flush_all,
  output logic              inv_line,
  output logic [DW-1:0]     inv_addr,
  output logic [DW-1:0]     base_addr,
  output logic              irq
);

  localparam int unsigned OPW = 3;

  // Named decode events
  logic      wr_base, wr_cmd, wr_inv, wr_clr, wr_mask;
  logic      op_hit, sw_rst, fault_ack;
  op_e       op_code;
  logic      paging, stall, fault_act, fault_wr;
  logic [DW-1:0]   fault_addr;
  logic [NSRC-1:0] raw, mask, masked, set_vec, clr_vec;

  always_comb begin
    wr_base = reg_we && (reg_addr == REG_AW'(OFF_BASE));
    wr_cmd  = reg_we && (reg_addr == REG_AW'(OFF_CMD));
    wr_inv  = reg_we && (reg_addr == REG_AW'(OFF_INV));
    wr_clr  = reg_we && (reg_addr == REG_AW'(OFF_CLR));
    wr_mask = reg_we && (reg_addr == REG_AW'(OFF_MASK));
    op_hit  = wr_cmd && (reg_wdata[DW-1:OPW] == '0);
    op_code = op_e'(reg_wdata[OPW-1:0]);
    sw_rst    = op_hit && (op_code == OP_SOFT_RST);
    fault_ack = op_hit && (op_code == OP_FAULT_ACK);
  end

  xlat_ctl_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_hit  (op_hit),
    .op_code (op_code),
    .paging  (paging),
    .stall   (stall),
    .flush   (flush_all)
  );

  xlat_ctl_fault #(.DW(DW)) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_rst    (sw_rst),
    .ack       (fault_ack),
    .evt_fault (evt_fault),
    .evt_write (evt_write),
    .evt_addr  (evt_addr),
    .active    (fault_act),
    .was_write (fault_wr),
    .addr      (fault_addr)
  );

  always_comb begin
    set_vec    = '0;
    set_vec[0] = evt_fault;
    set_vec[1] = evt_bus_err;
    clr_vec    = wr_clr ? reg_wdata[NSRC-1:0] : '0;
  end

  xlat_ctl_irq #(.NSRC(NSRC)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_rst     (sw_rst),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .mask_we    (wr_mask),
    .mask_wdata (reg_wdata[NSRC-1:0]),
    .raw        (raw),
    .mask       (mask),
    .masked     (masked),
    .irq        (irq)
  );

  // Directory base and single-line invalidate strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      inv_line  <= 1'b0;
      inv_addr  <= '0;
    end else begin
      inv_line <= wr_inv;
      if (wr_inv)       inv_addr  <= reg_wdata;
      if (sw_rst)       base_addr <= '0;
      else if (wr_base) base_addr <= keep_upper(reg_wdata, PAGE_SHIFT);
    end
  end

  assign xlat_en  = paging;
  assign stall_on = stall;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      REG_AW'(OFF_BASE):   reg_rdata = base_addr;
      REG_AW'(OFF_STATUS): reg_rdata = pack_status(paging, fault_act, stall,
                                                   dp_idle, dp_replay_empty, fault_wr);
      REG_AW'(OFF_FADDR):  reg_rdata = fault_addr;
      REG_AW'(OFF_RAW):    reg_rdata = DW'(raw);
      REG_AW'(OFF_MASK):   reg_rdata = DW'(mask);
      REG_AW'(OFF_MSKD):   reg_rdata = DW'(masked);
      default:             reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/xlat_ctl_chk.sv
module xlat_ctl_chk
  import xlat_ctl_pkg::*;
#(
  parameter int unsigned REG_AW = 8,
  parameter int unsigned DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic              evt_fault,
  input logic              evt_bus_err,
  input logic              xlat_en,
  input logic              stall_on,
  input logic              flush_all,
  input logic              inv_line,
  input logic [DW-1:0]     inv_addr,
  input logic [DW-1:0]     base_addr,
  input logic              irq
);

  AST_STALL_NEEDS_PAGING: assert property (@(posedge clk) disable iff (!rst_n)
    stall_on |-> xlat_en); // R4

  AST_FLUSH_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $past(reg_we && reg_addr == REG_AW'(OFF_CMD) && reg_wdata == DW'(OP_FLUSH))); // R5

  AST_INV_CARRIES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    inv_line |-> ($past(reg_we && reg_addr == REG_AW'(OFF_INV)) && inv_addr == $past(reg_wdata))); // R6

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt_fault || evt_bus_err || (reg_we && reg_addr == REG_AW'(OFF_MASK)))); // R8

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == REG_AW'(OFF_CMD) && reg_wdata == DW'(OP_SOFT_RST))
    |-> (base_addr == '0 && !xlat_en && !stall_on && !irq)); // R10

endmodule

bind xlat_ctl xlat_ctl_chk #(.REG_AW(REG_AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .evt_fault   (evt_fault),
  .evt_bus_err (evt_bus_err),
  .xlat_en     (xlat_en),
  .stall_on    (stall_on),
  .flush_all   (flush_all),
  .inv_line    (inv_line),
  .inv_addr    (inv_addr),
  .base_addr   (base_addr),
  .irq         (irq)
);

// File: tb/xlat_ctl_bench.sv
module xlat_ctl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        evt_fault = 1'b0, evt_write = 1'b0, evt_bus_err = 1'b0;
  logic [31:0] evt_addr = '0;
  logic        dp_idle = 1'b1, dp_replay_empty = 1'b1;
  logic        xlat_en, stall_on, flush_all, inv_line, irq;
  logic [31:0] inv_addr, base_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_ctl u_xlat_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_fault(evt_fault),
    .evt_write(evt_write), .evt_addr(evt_addr), .evt_bus_err(evt_bus_err),
    .dp_idle(dp_idle), .dp_replay_empty(dp_replay_empty), .xlat_en(xlat_en),
    .stall_on(stall_on), .flush_all(flush_all), .inv_line(inv_line),
    .inv_addr(inv_addr), .base_addr(base_addr), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // status with stall and paging as given, idle and replay-empty high
  function automatic logic [31:0] st(input logic pg, input logic flt, input logic stl, input logic fw);
    return {~stl, 25'd0, fw, 1'b1, 1'b1, stl, flt, pg};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h04, v); chk("R1", "status after reset", v, 32'h8000_0018);
    rd(8'h00, v); chk("R1", "base after reset", v, 32'h0);
    rd(8'h14, v); chk("R1", "raw after reset", v, 32'h0);
    chk("R1", "irq/xlat_en/stall", {29'd0, irq, xlat_en, stall_on}, 32'h0);
  endtask

  task automatic t_base();
    logic [31:0] v;
    wr(8'h00, 32'hCAFE_BABE);
    rd(8'h00, v); chk("R2", "base readback", v, 32'hCAFE_B000);
    chk("R2", "base_addr port", base_addr, 32'hCAFE_B000);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    wr(8'h08, 32'd6);
    wr(8'h08, 32'd2);
    rd(8'h04, v); chk("R4", "stall ignored with paging off", v, st(0, 0, 0, 0));
    wr(8'h08, 32'd0);
    rd(8'h04, v); chk("R3", "paging on", v, st(1, 0, 0, 0));
    chk("R3", "xlat_en", {31'd0, xlat_en}, 32'd1);
    wr(8'h08, 32'd2);
    rd(8'h04, v); chk("R4", "stall on", v, st(1, 0, 1, 0));
    chk("R4", "stall_on port", {31'd0, stall_on}, 32'd1);
    wr(8'h08, 32'd3);
    rd(8'h04, v); chk("R4", "stall off keeps paging", v, st(1, 0, 0, 0));
    wr(8'h08, 32'd2);
    wr(8'h08, 32'd1);
    rd(8'h04, v); chk("R3", "paging off clears stall", v, st(0, 0, 0, 0));
  endtask

  task automatic t_strobes();
    wr(8'h08, 32'd4);
    chk("R5", "flush_all high", {31'd0, flush_all}, 32'd1);
    chk("R5", "inv_line quiet on flush", {31'd0, inv_line}, 32'd0);
    @(negedge clk);
    chk("R5", "flush_all one cycle", {31'd0, flush_all}, 32'd0);
    wr(8'h10, 32'h1234_5678);
    chk("R6", "inv_line high", {31'd0, inv_line}, 32'd1);
    chk("R6", "inv_addr", inv_addr, 32'h1234_5678);
    @(negedge clk);
    chk("R6", "inv_line one cycle", {31'd0, inv_line}, 32'd0);
  endtask

  task automatic t_fault();
    logic [31:0] v;
    wr(8'h08, 32'd6);
    @(negedge clk);
    evt_fault = 1'b1; evt_write = 1'b1; evt_addr = 32'hDEAD_0123;
    @(negedge clk);
    evt_fault = 1'b0; evt_write = 1'b0;
    rd(8'h04, v); chk("R7", "fault status", v, st(0, 1, 0, 1));
    rd(8'h0C, v); chk("R7", "fault address", v, 32'hDEAD_0123);
    rd(8'h14, v); chk("R7", "raw fault bit", v, 32'h1);
    wr(8'h08, 32'd5);
    rd(8'h04, v); chk("R7", "fault ack clears bit1", v, st(0, 0, 0, 1));
  endtask

  task automatic t_irq();
    logic [31:0] v;
    chk("R8", "irq masked off", {31'd0, irq}, 32'd0);
    rd(8'h20, v); chk("R8", "masked zero", v, 32'h0);
    wr(8'h1C, 32'h3);
    chk("R8", "irq after unmask", {31'd0, irq}, 32'd1);
    @(negedge clk);
    evt_bus_err = 1'b1;
    @(negedge clk);
    evt_bus_err = 1'b0;
    rd(8'h14, v); chk("R8", "raw both", v, 32'h3);
    wr(8'h1C, 32'h2);
    rd(8'h20, v); chk("R8", "masked bus only", v, 32'h2);
    rd(8'h1C, v); chk("R8", "mask readback", v, 32'h2);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'h18, 32'h1);
    rd(8'h14, v); chk("R9", "clear fault bit", v, 32'h2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h18; reg_wdata = 32'h2; evt_bus_err = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; evt_bus_err = 1'b0;
    rd(8'h14, v); chk("R9", "event beats clear", v, 32'h2);
    wr(8'h18, 32'h2);
    rd(8'h14, v); chk("R9", "clear bus bit", v, 32'h0);
    chk("R9", "irq drops", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr(8'h00, 32'h8765_4321);
    wr(8'h08, 32'd0);
    wr(8'h1C, 32'h3);
    @(negedge clk); evt_bus_err = 1'b1;
    @(negedge clk); evt_bus_err = 1'b0;
    wr(8'h08, 32'd6);
    rd(8'h00, v); chk("R10", "base zero", v, 32'h0);
    rd(8'h04, v); chk("R10", "status reset", v, 32'h8000_0018);
    rd(8'h1C, v); chk("R10", "mask reset", v, 32'h0);
    rd(8'h14, v); chk("R10", "raw reset", v, 32'h0);
    chk("R10", "irq/xlat_en", {30'd0, irq, xlat_en}, 32'd0);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    rd(8'h24, v); chk("R11", "offset 0x24", v, 32'h0);
    rd(8'h3C, v); chk("R11", "offset 0x3C", v, 32'h0);
    wr(8'h08, 32'd0);
    wr(8'h08, 32'd7);
    rd(8'h04, v); chk("R11", "cmd 7 no effect", v, st(1, 0, 0, 0));
    chk("R11", "cmd 7 no flush", {31'd0, flush_all}, 32'd0);
    wr(8'h08, 32'h0000_0101);
    rd(8'h04, v); chk("R11", "wide cmd no effect", v, st(1, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_modes();
    t_strobes();
    t_fault();
    t_irq();
    t_clear();
    t_force();
    t_misc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule